// File: doc/BRIEF.md
# Flywheel Frame Pulse Framer

This block turns a backplane 8 kHz frame pulse, which arrives asynchronously and with jitter, into a clean frame timing reference in the core clock domain. At the default setting the core clock is 65.536 MHz, so one frame lasts 8,192 core cycles. The framer first hunts for a pulse. It then checks that following pulses repeat at exactly one frame spacing. Once they do, it runs on its own phase counter, which acts as a flywheel. While locked, pulses that wander by a few cycles around the expected position, and pulses that appear anywhere else, have no effect on frame timing. Only a run of frames with no pulse near the expected position drops the lock.

The switch logic receives a one-cycle frame strobe and the running cycle-in-frame count. Two mezzanine-site outputs are derived from the same counter, so they stay locked to the backplane: a bit clock at one eighth of the core rate and a frame pulse. A state code and a lock flag can be read by software, and a software search request returns the framer to the hunting state on any cycle.

Top module: `fp_flywheel_framer`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, fr_status is 0, lock_ok is 0, and frame_strobe, mz_clk and mz_fp are all 0.
- R2: bp_fp passes through two synchronising flops and an edge detector. A pulse first sampled high at clock edge k is acted on at edge k+2. A level held high for many cycles counts as a single pulse.
- R3: Three consecutive pulses, each exactly FRAME_CYCLES after the one before, take the framer from search, through verify, to locked. lock_ok rises in the cycle after the third pulse is acted on, and never before it.
- R4: In verify, a pulse at any spacing other than FRAME_CYCLES restarts verification with that pulse as the new first pulse. If no pulse arrives at the expected position, the framer returns to search.
- R5: While locked, frame_strobe is high for exactly one cycle every FRAME_CYCLES cycles, and frame_phase counts up by one each cycle and wraps modulo FRAME_CYCLES. frame_strobe sits where frame_phase is 0. A pulse up to JIT_TOL cycles early or late does not move this timing.
- R6: While locked, a pulse outside the ±JIT_TOL window around phase 0 leaves the frame timing and the lock state unchanged.
- R7: While locked, MISS_MAX consecutive frames with no pulse inside the window return the framer to search and clear lock_ok. A pulse inside the window resets the run of missed frames.
- R8: cpu_search held high at a clock edge puts the framer in search, with lock_ok low, from the next cycle, whatever state it was in.
- R9: While locked, mz_clk has a period of MZ_DIV cycles at 50% duty. It goes high one cycle after a phase that is a multiple of MZ_DIV, which gives FRAME_CYCLES/MZ_DIV rising edges per frame. When not locked it stays low.
- R10: While locked, mz_fp is high for MZ_DIV cycles starting one cycle after frame_strobe. When not locked it stays low.
- R11: fr_status gives the state: 0 for search, 1 for verify, 2 for locked. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bp_fp | input | 1 | Backplane frame pulse, asynchronous, active high |
| cpu_search | input | 1 | Software request to return to search |
| frame_strobe | output | 1 | One-cycle frame start while locked |
| frame_phase | output | $clog2(FRAME_CYCLES) | Cycle within the frame |
| lock_ok | output | 1 | High while locked |
| fr_status | output | 2 | Framer state code |
| mz_clk | output | 1 | Mezzanine bit clock |
| mz_fp | output | 1 | Mezzanine frame pulse |

## Verification
The first stimulus is an exactly periodic pulse train. It measures the lock latency and shows where the strobe lands relative to each pulse. Pulse trains with offsets inside ±JIT_TOL, random stray pulses, and a pulse pushed just outside the window separate a flywheel from a design that simply retimes every pulse: with a flywheel, the strobe position never moves. Runs of missing pulses that stop one frame short of the limit, and runs that reach it, pin the exact loss threshold. Phase jumps during verify, a missing pulse during verify, and very wide pulses exercise the restart path and the edge detector.

// File: rtl/fpf_pkg.sv
// Package fpf_pkg
// Types shared by the framer blocks. The state encoding is visible at the
// fr_status port, so the values are fixed.
package fpf_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } fpf_state_t;
endpackage

// File: rtl/fpf_sync.sv
// Module fpf_sync
// Brings an asynchronous pulse into the clock domain through STAGES flops,
// then produces a one-cycle rise indication.
// Assumes: STAGES >= 2; rise is driven from flops only, never from the raw input.
module fpf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sh_q;
    logic              last_q;

    // Synchroniser chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            last_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], async_in};
            last_q <= sh_q[STAGES-1];
        end
    end

    // Rising edge of the synchronised level.
    always_comb begin
        rise = sh_q[STAGES-1] & ~last_q;
    end
endmodule

// File: rtl/fpf_fsm.sv
// Module fpf_fsm
// Search / verify / locked state machine with a flywheel phase counter.
// In verify, each pulse must land exactly at phase 0. In locked, timing comes
// from the counter only; pulses in the window just mark the frame as seen.
// Assumes: rise is synchronous and one cycle wide; JIT_TOL < FRAME_CYCLES/2.
module fpf_fsm
    import fpf_pkg::*;
#(
    parameter int FRAME_CYCLES = 8192,
    parameter int LOCK_PULSES  = 3,
    parameter int JIT_TOL      = 2,
    parameter int MISS_MAX     = 4,
    localparam int PH_W        = $clog2(FRAME_CYCLES),
    localparam int GD_W        = $clog2(LOCK_PULSES + 1),
    localparam int MS_W        = $clog2(MISS_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rise,
    input  logic            force_search,
    output fpf_state_t      state,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_CYCLES - 1);
    localparam logic [PH_W-1:0] WIN_HI  = PH_W'(JIT_TOL);
    localparam logic [PH_W-1:0] WIN_LO  = PH_W'(FRAME_CYCLES - JIT_TOL);

    fpf_state_t      st_q;
    logic [PH_W-1:0] ph_q;
    logic [GD_W-1:0] good_q;
    logic [MS_W-1:0] miss_q;
    logic            hit_q;

    logic [PH_W-1:0] ph_next;
    logic            in_win;
    logic            at_zero;
    logic            eval_pt;
    logic            hit_now;
    logic            lock_done;
    logic            miss_done;

    // Next phase value, the acceptance window and the per-frame decision flags.
    always_comb begin
        ph_next   = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
        in_win    = (ph_q <= WIN_HI) || (ph_q >= WIN_LO);
        at_zero   = (ph_q == '0);
        eval_pt   = (ph_q == WIN_HI);
        hit_now   = hit_q || (rise && in_win);
        lock_done = (32'(good_q) + 1) >= LOCK_PULSES;
        miss_done = (32'(miss_q) + 1) >= MISS_MAX;
    end

    // State, phase, pulse-count and miss-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n || force_search) begin
            st_q   <= ST_SEARCH;
            ph_q   <= '0;
            good_q <= '0;
            miss_q <= '0;
            hit_q  <= 1'b0;
        end else begin
            case (st_q)
                ST_SEARCH: begin
                    if (rise) begin
                        st_q   <= ST_VERIFY;
                        ph_q   <= PH_W'(1);
                        good_q <= GD_W'(1);
                    end
                end
                ST_VERIFY: begin
                    ph_q <= ph_next;
                    if (rise) begin
                        if (at_zero) begin
                            if (lock_done) begin
                                st_q   <= ST_LOCKED;
                                good_q <= '0;
                                miss_q <= '0;
                                hit_q  <= 1'b1;
                            end else begin
                                good_q <= good_q + 1'b1;
                            end
                        end else begin
                            ph_q   <= PH_W'(1);
                            good_q <= GD_W'(1);
                        end
                    end else if (at_zero) begin
                        st_q   <= ST_SEARCH;
                        ph_q   <= '0;
                        good_q <= '0;
                    end
                end
                ST_LOCKED: begin
                    ph_q <= ph_next;
                    if (eval_pt) begin
                        hit_q <= 1'b0;
                        if (hit_now) begin
                            miss_q <= '0;
                        end else if (miss_done) begin
                            st_q   <= ST_SEARCH;
                            ph_q   <= '0;
                            miss_q <= '0;
                        end else begin
                            miss_q <= miss_q + 1'b1;
                        end
                    end else if (rise && in_win) begin
                        hit_q <= 1'b1;
                    end
                end
                default: begin
                    st_q <= ST_SEARCH;
                    ph_q <= '0;
                end
            endcase
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        state = st_q;
        phase = ph_q;
    end
endmodule

// File: rtl/fpf_mezz.sv
// Module fpf_mezz
// Derives the mezzanine bit clock and frame pulse from the flywheel phase.
// Both outputs are registered and held low while not locked.
// Assumes: MZ_DIV is a power of two that divides FRAME_CYCLES.
module fpf_mezz #(
    parameter int FRAME_CYCLES = 8192,
    parameter int MZ_DIV       = 8,
    localparam int PH_W        = $clog2(FRAME_CYCLES),
    localparam int DV_W        = $clog2(MZ_DIV)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            locked,
    input  logic [PH_W-1:0] phase,
    output logic            mz_clk,
    output logic            mz_fp
);
    logic clk_d;
    logic fp_d;

    // High half of each bit period, and the first bit period of each frame.
    always_comb begin
        clk_d = locked && (phase[DV_W-1:0] < DV_W'(MZ_DIV / 2));
        fp_d  = locked && (phase < PH_W'(MZ_DIV));
    end

    // Output registers, so the outputs are free of glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mz_clk <= 1'b0;
            mz_fp  <= 1'b0;
        end else begin
            mz_clk <= clk_d;
            mz_fp  <= fp_d;
        end
    end
endmodule

// File: rtl/fp_flywheel_framer.sv
// Module fp_flywheel_framer
// Top of the frame pulse framer: synchroniser, flywheel state machine and
// mezzanine timing generator.
// Assumes: bp_fp is asynchronous; cpu_search is already synchronous to clk.
module fp_flywheel_framer
    import fpf_pkg::*;
#(
    parameter int FRAME_CYCLES = 8192,
    parameter int LOCK_PULSES  = 3,
    parameter int JIT_TOL      = 2,
    parameter int MISS_MAX     = 4,
    parameter int MZ_DIV       = 8,
    localparam int PH_W        = $clog2(FRAME_CYCLES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bp_fp,
    input  logic            cpu_search,
    output logic            frame_strobe,
    output logic [PH_W-1:0] frame_phase,
    output logic            lock_ok,
    output logic [1:0]      fr_status,
    output logic            mz_clk,
    output logic            mz_fp
);
    logic            fp_rise;
    fpf_state_t      st;
    logic [PH_W-1:0] ph;

    fpf_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bp_fp),
        .rise     (fp_rise)
    );

    fpf_fsm #(
        .FRAME_CYCLES (FRAME_CYCLES),
        .LOCK_PULSES  (LOCK_PULSES),
        .JIT_TOL      (JIT_TOL),
        .MISS_MAX     (MISS_MAX)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rise         (fp_rise),
        .force_search (cpu_search),
        .state        (st),
        .phase        (ph)
    );

    fpf_mezz #(
        .FRAME_CYCLES (FRAME_CYCLES),
        .MZ_DIV       (MZ_DIV)
    ) u_mezz (
        .clk    (clk),
        .rst_n  (rst_n),
        .locked (lock_ok),
        .phase  (ph),
        .mz_clk (mz_clk),
        .mz_fp  (mz_fp)
    );

    // Status and frame-strobe outputs.
    always_comb begin
        lock_ok      = (st == ST_LOCKED);
        fr_status    = st;
        frame_phase  = ph;
        frame_strobe = lock_ok && (ph == '0);
    end
endmodule

// File: rtl/fpf_checker.sv
// Module fpf_checker
// Timing properties of the framer, attached to every instance of the top by bind.
module fpf_checker #(
    parameter int FRAME_CYCLES = 8192,
    localparam int PH_W        = $clog2(FRAME_CYCLES)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_search,
    input logic            frame_strobe,
    input logic [PH_W-1:0] frame_phase,
    input logic            lock_ok,
    input logic [1:0]      fr_status,
    input logic            mz_clk,
    input logic            mz_fp
);
    int   gap;
    logic gap_ok;

    // Cycles since the last strobe, counted only during an unbroken lock.
    always_ff @(posedge clk) begin
        if (!rst_n || !lock_ok) begin
            gap    <= 0;
            gap_ok <= 1'b0;
        end else if (frame_strobe) begin
            gap    <= 0;
            gap_ok <= 1'b1;
        end else begin
            gap <= gap + 1;
        end
    end

    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && gap_ok) |-> (gap == FRAME_CYCLES - 1)); // R5

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_ok && $past(lock_ok)) |->
        (32'(frame_phase) == (32'($past(frame_phase)) + 1) % FRAME_CYCLES)); // R5

    AST_SEARCH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_search |=> (fr_status == 2'd0 && !lock_ok)); // R8

    AST_LOCK_VIA_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_ok) |-> ($past(fr_status) == 2'd1)); // R3

    AST_MZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_ok && !$past(lock_ok)) |-> (!mz_clk && !mz_fp)); // R9

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        fr_status != 2'd3); // R11
endmodule

bind fp_flywheel_framer fpf_checker #(.FRAME_CYCLES(FRAME_CYCLES)) u_fpf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_search   (cpu_search),
    .frame_strobe (frame_strobe),
    .frame_phase  (frame_phase),
    .lock_ok      (lock_ok),
    .fr_status    (fr_status),
    .mz_clk       (mz_clk),
    .mz_fp        (mz_fp)
);

// File: tb/fp_flywheel_framer_tb.sv
`timescale 1ns/1ps
module fp_flywheel_framer_tb;
    localparam int F    = 256;
    localparam int W    = 2;
    localparam int DIV  = 8;
    localparam int BASE = 8;
    localparam int PH_W = $clog2(F);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bp_fp = 1'b0;
    logic cpu_search = 1'b0;
    logic frame_strobe, lock_ok, mz_clk, mz_fp;
    logic [PH_W-1:0] frame_phase;
    logic [1:0] fr_status;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // Per-frame observations.
    int n_strobe, strobe_idx, mzc_rises, mzfp_hi, mzfp_first, ph20;
    logic mzc_prev = 1'b0;

    always #2.5 clk = ~clk;

    fp_flywheel_framer #(
        .FRAME_CYCLES (F),
        .LOCK_PULSES  (3),
        .JIT_TOL      (W),
        .MISS_MAX     (4),
        .MZ_DIV       (DIV)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bp_fp        (bp_fp),
        .cpu_search   (cpu_search),
        .frame_strobe (frame_strobe),
        .frame_phase  (frame_phase),
        .lock_ok      (lock_ok),
        .fr_status    (fr_status),
        .mz_clk       (mz_clk),
        .mz_fp        (mz_fp)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected strobe index within a bench frame, for lock phase offset off.
    function automatic int exp_strobe(input int off);
        return BASE + off + 2;
    endfunction

    // Index at which a strobe at index s is followed by the mezzanine frame pulse.
    function automatic int exp_mzfp_first(input int s);
        return s + 1;
    endfunction

    // One frame of F cycles: optional pulse at BASE+off, optional stray pulse.
    task automatic frame(input int off, input bit present, input int width,
                         input bit spur, input int spur_pos);
        n_strobe = 0; strobe_idx = -1; mzc_rises = 0; mzfp_hi = 0;
        mzfp_first = -1; ph20 = -1;
        for (int i = 0; i < F; i++) begin
            @(negedge clk);
            if (frame_strobe) begin n_strobe++; strobe_idx = i; end
            if (mz_clk && !mzc_prev) mzc_rises++;
            mzc_prev = mz_clk;
            if (mz_fp) begin
                mzfp_hi++;
                if (mzfp_first < 0) mzfp_first = i;
            end
            if (i == 20) ph20 = int'(frame_phase);
            bp_fp = (present && i >= BASE + off && i < BASE + off + width) ||
                    (spur && i >= spur_pos && i < spur_pos + 3);
        end
    endtask

    task automatic search_cmd();
        @(negedge clk);
        cpu_search = 1'b1;
        @(negedge clk);
        cpu_search = 1'b0;
        chk(fr_status == 2'd0 && !lock_ok, "R8", "search after command",
            int'(fr_status), 0);
    endtask

    task automatic check_locked_frame(input string req, input int off);
        chk(lock_ok == 1'b1, req, "lock held", int'(lock_ok), 1);
        chk(n_strobe == 1 && strobe_idx == exp_strobe(off), req, "strobe position",
            strobe_idx, exp_strobe(off));
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int absent_run;
        int off;
        bit present;
        void'($urandom(32'h1F2E3D4C));
        repeat (4) @(negedge clk);
        // R1: values during reset and just after
        chk(fr_status == 0 && !lock_ok && !frame_strobe && !mz_clk && !mz_fp,
            "R1", "in reset", int'(fr_status), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fr_status == 0 && !lock_ok && !frame_strobe && !mz_clk && !mz_fp,
            "R1", "after reset", int'(lock_ok), 0);

        // R3 / R11: lock sequence with exact spacing
        frame(0, 1, 3, 0, 0);
        chk(fr_status == 2'd1, "R11", "verify code", int'(fr_status), 1);
        frame(0, 1, 3, 0, 0);
        chk(!lock_ok && fr_status == 2'd1, "R3", "no lock after two", int'(lock_ok), 0);
        frame(0, 1, 3, 0, 0);
        chk(lock_ok && fr_status == 2'd2, "R3", "lock after three", int'(fr_status), 2);

        // R2 / R5 / R9 / R10: a full locked frame
        frame(0, 1, 3, 0, 0);
        check_locked_frame("R2", 0);
        chk(ph20 == 20 - exp_strobe(0), "R5", "phase count", ph20, 20 - exp_strobe(0));
        chk(mzc_rises == F / DIV, "R9", "mz clock edges", mzc_rises, F / DIV);
        chk(mzfp_hi == DIV && mzfp_first == exp_mzfp_first(exp_strobe(0)), "R10",
            "mz frame pulse", mzfp_first, exp_mzfp_first(exp_strobe(0)));

        // R5: jitter at the window edges
        frame(-W, 1, 3, 0, 0);
        check_locked_frame("R5", 0);
        frame(W, 1, 3, 0, 0);
        check_locked_frame("R5", 0);

        // R6: stray pulse, and a pulse just outside the window
        frame(0, 1, 3, 1, 100);
        check_locked_frame("R6", 0);
        frame(W + 1, 1, 3, 0, 0);
        check_locked_frame("R6", 0);
        frame(0, 1, 3, 0, 0);

        // R7: three misses keep lock, a hit clears the run, four misses lose it
        for (int k = 0; k < 3; k++) frame(0, 0, 3, 0, 0);
        check_locked_frame("R7", 0);
        frame(0, 1, 3, 0, 0);
        for (int k = 0; k < 3; k++) frame(0, 0, 3, 0, 0);
        chk(lock_ok == 1'b1, "R7", "lock after three misses", int'(lock_ok), 1);
        frame(0, 0, 3, 0, 0);
        chk(!lock_ok && fr_status == 2'd0, "R7", "loss after four misses",
            int'(fr_status), 0);

        // Re-lock, then random jitter, strays and short gaps (R5, R6)
        for (int k = 0; k < 3; k++) frame(0, 1, 3, 0, 0);
        chk(lock_ok == 1'b1, "R3", "relock", int'(lock_ok), 1);
        absent_run = 0;
        for (int k = 0; k < 40; k++) begin
            off = int'($urandom_range(2 * W)) - W;
            present = ($urandom_range(7) != 0) || (absent_run >= 2);
            absent_run = present ? 0 : absent_run + 1;
            frame(off, present, 1 + int'($urandom_range(4)), 1'($urandom_range(1)),
                  30 + int'($urandom_range(F - 60)));
            check_locked_frame("R6", 0);
        end

        // R8 while locked; R4 restart on a phase jump during verify
        search_cmd();
        frame(0, 1, 3, 0, 0);
        chk(fr_status == 2'd1, "R4", "verify entered", int'(fr_status), 1);
        frame(5, 1, 3, 0, 0);
        frame(5, 1, 3, 0, 0);
        chk(!lock_ok && fr_status == 2'd1, "R4", "restart not locked", int'(lock_ok), 0);
        frame(5, 1, 3, 0, 0);
        chk(lock_ok == 1'b1, "R4", "locked on new phase", int'(lock_ok), 1);
        frame(5, 1, 3, 0, 0);
        check_locked_frame("R4", 5);

        // R4: missing pulse during verify returns to search
        search_cmd();
        frame(0, 1, 3, 0, 0);
        frame(0, 0, 3, 0, 0);
        chk(fr_status == 2'd0, "R4", "verify miss to search", int'(fr_status), 0);

        // R2: wide pulses count once each
        search_cmd();
        frame(0, 1, 40, 0, 0);
        frame(0, 1, 40, 0, 0);
        chk(!lock_ok && fr_status == 2'd1, "R2", "wide pulses two", int'(fr_status), 1);
        frame(0, 1, 40, 0, 0);
        chk(lock_ok == 1'b1, "R2", "wide pulses lock", int'(lock_ok), 1);

        // R9 / R10: outputs quiet once unlocked
        search_cmd();
        frame(0, 0, 3, 0, 0);
        chk(mzc_rises == 0 && mzfp_hi == 0 && n_strobe == 0, "R9", "quiet unlocked",
            mzc_rises + mzfp_hi, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule